// File: doc/BRIEF.md
# External Access Wait-State Generator

This block stretches external bus accesses by a programmable number of wait cycles. A single 16-bit configuration word sets the count for external data-memory accesses and for four equal regions of an 11-bit I/O space. The word sits at data address 0x3FFE and is loaded through a simple write port. When the bus logic starts an external access, it raises a one-cycle start strobe and says whether the access targets I/O or data memory. For an I/O access it also gives the I/O address. The block then holds `stall` high for the required number of cycles and pulses `done` when the access may finish.

A global mode bit changes how a field value N is read. In normal mode N is used as it stands, giving 0 to 7 wait cycles. In stretched mode the count becomes 2N+1, giving up to 15. The wait count is captured when the access starts, so a write to the register only affects later accesses. Internal accesses never reach this block.

The control is a three-state machine. `IDLE` waits for a start. Transition *start-long* goes to `WAIT` when the count is two or more. Transition *start-short* goes straight to `DONE` when the count is one. Transition *start-zero* stays in `IDLE` and signals completion at once. `WAIT` counts down and takes transition *last-wait* to `DONE`. `DONE` always takes transition *retire* back to `IDLE`.

Top module: `xbus_wait_gen`

## Requirements
- R1: After reset every wait field is all ones (value 7) and the mode bit is 0, so any access gets 7 wait cycles; `stall` and `done` are low while no access is running.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 0x3FFE loads `cfg_wdata` into the configuration word at the next clock edge. A write to any other address, or `cfg_wdata` presented while `cfg_we` is low, leaves the word unchanged.
- R3: The layout of the configuration word is fixed: bit 15 is the mode bit, bits 14:12 are the data-memory field, and bits 11:9, 8:6, 5:3 and 2:0 are the fields for I/O regions 3, 2, 1 and 0.
- R4: An I/O access (`acc_io`=1) uses the field of the region given by `io_addr[10:9]`: 0x000–0x1FF is region 0, 0x200–0x3FF is region 1, 0x400–0x5FF is region 2, and 0x600–0x7FF is region 3. A data access (`acc_io`=0) uses the data-memory field.
- R5: With the mode bit at 0, a field value N gives N wait cycles (0 to 7).
- R6: With the mode bit at 1, a field value N gives 2N+1 wait cycles (1 to 15).
- R7: For W wait cycles, `stall` is high from the start cycle through W consecutive cycles. `done` is a one-cycle pulse in the cycle after the last wait cycle. When W is 0, `done` is high in the start cycle and `stall` never rises.
- R8: A start strobe that arrives while an access is stalling or completing is ignored: it does not lengthen the access and does not start a new one.
- R9: The wait count is fixed when an access starts. A register write during the access, or in the same cycle as its start, changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 14 | Data address of the write |
| cfg_wdata | input | 16 | Write data |
| acc_start | input | 1 | One-cycle strobe marking the start of an external access |
| acc_io | input | 1 | 1 = I/O access, 0 = data-memory access |
| io_addr | input | 11 | I/O address of the access |
| stall | output | 1 | High for each wait cycle of the access |
| done | output | 1 | One-cycle pulse when the access completes |

## Verification
Inputs change on the falling edge, and outputs are sampled 1 ns after it, well clear of the rising edge. If an access with W waits starts in cycle 0, `stall` is due high in cycles 0 to W-1 and `done` in cycle W. This holds for W = 0 too, because both outputs follow the start strobe in the same cycle. The bench therefore compares both outputs in every cycle from 0 to W+2, so a pulse that comes early, late or twice, or a stall that is too long or too short, is caught at the exact cycle. A register write takes one rising edge to land, so every later access sees the new value.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } wait_state_t;

endpackage

// File: rtl/xbus_wait_cfg.sv
module xbus_wait_cfg #(
    parameter int          REG_W     = 16,
    parameter int          ADDR_W    = 14,
    parameter logic [13:0] REG_ADDR  = 14'h3FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  cfg
);
    // mode bit clear, every wait field all ones
    localparam logic [REG_W-1:0] RESET_VAL = {1'b0, {(REG_W-1){1'b1}}};

    logic hit;
    assign hit = we && (addr == ADDR_W'(REG_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= RESET_VAL;
        else if (hit)
            cfg <= wdata;
    end

    // R2: an addressed write lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit) |-> cfg == $past(wdata));

    // R2: without an addressed write the word holds
    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(hit) |-> $stable(cfg));

endmodule

// File: rtl/xbus_wait_sel.sv
module xbus_wait_sel #(
    parameter int FIELD_W = 3,
    parameter int REGIONS = 4,
    parameter int IO_AW   = 11
) (
    input  logic [(REGIONS+1)*FIELD_W:0] cfg,
    input  logic                         acc_io,
    input  logic [IO_AW-1:0]             io_addr,
    output logic [FIELD_W:0]             wcount
);
    localparam int RSEL_W   = $clog2(REGIONS);
    localparam int DM_LSB   = REGIONS * FIELD_W;
    localparam int MODE_BIT = DM_LSB + FIELD_W;

    logic [FIELD_W-1:0] region_f [REGIONS];
    logic [RSEL_W-1:0]  ridx;
    logic [FIELD_W-1:0] nsel;

    // field of region r sits at bits r*FIELD_W upward
    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        assign region_f[r] = cfg[r*FIELD_W +: FIELD_W];
    end

    // region index comes from the top address bits
    assign ridx = io_addr[IO_AW-1 -: RSEL_W];

    always_comb begin
        nsel = acc_io ? region_f[ridx] : cfg[DM_LSB +: FIELD_W];
        if (cfg[MODE_BIT])
            wcount = {nsel, 1'b1};   // 2N+1
        else
            wcount = {1'b0, nsel};   // N
    end

endmodule

// File: rtl/xbus_wait_fsm.sv
module xbus_wait_fsm
    import xbus_wait_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic [CNT_W-1:0] wcount,
    output logic             stall,
    output logic             done
);
    wait_state_t      state, state_nx;
    logic [CNT_W-1:0] remain, remain_nx;

    // next-state and counter logic
    always_comb begin
        state_nx  = state;
        remain_nx = remain;
        unique case (state)
            ST_IDLE: begin
                if (acc_start) begin
                    if (wcount > CNT_W'(1)) begin          // start-long
                        state_nx  = ST_WAIT;
                        remain_nx = wcount - CNT_W'(1);
                    end else if (wcount == CNT_W'(1)) begin // start-short
                        state_nx  = ST_DONE;
                    end                                      // start-zero stays idle
                end
            end
            ST_WAIT: begin
                if (remain == CNT_W'(1))                     // last-wait
                    state_nx = ST_DONE;
                else
                    remain_nx = remain - CNT_W'(1);
            end
            ST_DONE: state_nx = ST_IDLE;                     // retire
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            state  <= state_nx;
            remain <= remain_nx;
        end
    end

    // outputs
    always_comb begin
        stall = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                stall = acc_start && (wcount != '0);
                done  = acc_start && (wcount == '0);
            end
            ST_WAIT: stall = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
    end

    // R7: stall and done never coincide
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    // R7: the end of a stall is the completion cycle
    a_r7_stall_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(stall) |-> done);

    // R8/R9: a running countdown steps by exactly one, whatever the inputs do
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && state == ST_WAIT && $past(state) == ST_WAIT |->
            remain == $past(remain) - CNT_W'(1));

    // R7: the wait state never holds an exhausted count
    a_r7_wait_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT |-> remain != '0);

endmodule

// File: rtl/xbus_wait_gen.sv
module xbus_wait_gen #(
    parameter int          FIELD_W  = 3,
    parameter int          REGIONS  = 4,
    parameter int          IO_AW    = 11,
    parameter int          ADDR_W   = 14,
    parameter logic [13:0] REG_ADDR = 14'h3FFE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [(REGIONS+1)*FIELD_W:0] cfg_wdata,
    input  logic                         acc_start,
    input  logic                         acc_io,
    input  logic [IO_AW-1:0]             io_addr,
    output logic                         stall,
    output logic                         done
);
    localparam int REG_W = (REGIONS + 1) * FIELD_W + 1;
    localparam int CNT_W = FIELD_W + 1;

    logic [REG_W-1:0] cfg;
    logic [CNT_W-1:0] wcount;

    xbus_wait_cfg #(
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    xbus_wait_sel #(
        .FIELD_W (FIELD_W),
        .REGIONS (REGIONS),
        .IO_AW   (IO_AW)
    ) u_sel (
        .cfg     (cfg),
        .acc_io  (acc_io),
        .io_addr (io_addr),
        .wcount  (wcount)
    );

    xbus_wait_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .wcount    (wcount),
        .stall     (stall),
        .done      (done)
    );

endmodule

// File: tb/xbus_wait_gen_test.sv
module xbus_wait_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        acc_start = 1'b0;
    logic        acc_io = 1'b0;
    logic [10:0] io_addr = '0;
    logic        stall, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    xbus_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_start(acc_start), .acc_io(acc_io),
        .io_addr(io_addr), .stall(stall), .done(done)
    );

    // {config word, io select, io address, expected waits}
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 1'b0, 11'h000, 4'd0},   // R5 zero waits
        {16'h1000, 1'b0, 11'h000, 4'd1},   // R3 data field
        {16'h5000, 1'b0, 11'h000, 4'd5},
        {16'h029C, 1'b1, 11'h000, 4'd4},   // R4 region 0
        {16'h029C, 1'b1, 11'h1FF, 4'd4},
        {16'h029C, 1'b1, 11'h200, 4'd3},   // R4 region 1
        {16'h029C, 1'b1, 11'h3FF, 4'd3},
        {16'h029C, 1'b1, 11'h400, 4'd2},   // R4 region 2
        {16'h029C, 1'b1, 11'h5FF, 4'd2},
        {16'h029C, 1'b1, 11'h600, 4'd1},   // R4 region 3
        {16'h029C, 1'b1, 11'h7FF, 4'd1},
        {16'h829C, 1'b1, 11'h000, 4'd9},   // R6 2N+1
        {16'h829C, 1'b1, 11'h400, 4'd5},
        {16'h829C, 1'b1, 11'h600, 4'd3},
        {16'h8000, 1'b0, 11'h000, 4'd1},   // R6 N=0 gives 1
        {16'hF000, 1'b0, 11'h000, 4'd15},  // R6 maximum
        {16'h0007, 1'b1, 11'h001, 4'd7},   // R5 region maximum
        {16'h0007, 1'b0, 11'h000, 4'd0}    // R3 data field unaffected
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [13:0] a, input logic [15:0] d, input logic we);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // kind: 0 plain, 1 write mid-access, 2 extra starts while busy, 3 write with start
    task automatic run_access(input logic io, input logic [10:0] a, input int exp,
                              input int kind, input logic [15:0] wd, input string req);
        bit bad = 0;
        int nstall = 0;
        int done_at = -1;
        @(negedge clk);
        acc_start = 1'b1; acc_io = io; io_addr = a;
        if (kind == 3) begin
            cfg_we = 1'b1; cfg_addr = 14'h3FFE; cfg_wdata = wd;
        end
        for (int c = 0; c <= exp + 2; c++) begin
            #1;
            if (stall !== (c < exp)) bad = 1;
            if (done !== (c == exp)) bad = 1;
            if (stall === 1'b1) nstall++;
            if (done === 1'b1 && done_at < 0) done_at = c;
            @(negedge clk);
            acc_start = (kind == 2) && (c == 1 || c == exp - 1);
            cfg_we = (kind == 1) && (c == 0);
            cfg_addr = 14'h3FFE; cfg_wdata = wd;
        end
        acc_start = 1'b0; cfg_we = 1'b0;
        if (bad)
            $display("  (%s: stall cycles=%0d done at cycle %0d, want %0d / %0d)",
                     req, nstall, done_at, exp, exp);
        check(!bad, req, nstall, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(stall === 1'b0 && done === 1'b0, "R1 idle outputs", int'(stall) + int'(done), 0);

        // R1 reset defaults
        run_access(1'b0, 11'h000, 7, 0, 16'h0, "R1 data default");
        run_access(1'b1, 11'h7FF, 7, 0, 16'h0, "R1 io default");

        // R2 stray writes ignored
        write_cfg(14'h3FFD, 16'h0000, 1'b1);
        write_cfg(14'h3FFE, 16'h0000, 1'b0);
        run_access(1'b0, 11'h000, 7, 0, 16'h0, "R2 stray write");

        // table walk (R2..R7)
        for (int i = 0; i < NV; i++) begin
            write_cfg(14'h3FFE, VEC[i][31:16], 1'b1);
            run_access(VEC[i][15], VEC[i][14:4], int'(VEC[i][3:0]), 0, 16'h0, "R7 vector");
        end

        // R9 write during access
        write_cfg(14'h3FFE, 16'h5000, 1'b1);
        run_access(1'b0, 11'h000, 5, 1, 16'h2000, "R9 mid write");
        run_access(1'b0, 11'h000, 2, 0, 16'h0, "R9 next access");

        // R9 write in the start cycle
        run_access(1'b0, 11'h000, 2, 3, 16'h6000, "R9 same-cycle write");
        run_access(1'b0, 11'h000, 6, 0, 16'h0, "R9 after same-cycle");

        // R8 starts while busy ignored
        write_cfg(14'h3FFE, 16'h5000, 1'b1);
        run_access(1'b0, 11'h000, 5, 2, 16'h0, "R8 busy start");
        write_cfg(14'h3FFE, 16'h1000, 1'b1);
        run_access(1'b0, 11'h000, 1, 0, 16'h0, "R8 idle after");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule